// File: doc/BRIEF.md
# S/PDIF Received Sample Formatter

This block sits behind a biphase decoder in a digital audio receiver. The decoder hands it one subframe per strobe: a 24-bit audio field, the validity, user, channel-status and parity bits, and a flag that marks the first subframe of a block. The block uses a small mode word to decide whether each subframe is accepted. It shapes an accepted sample into a 32-bit word and parks that word in a holding register, where a reader consumes it.

Acceptance can depend on the validity bit, on the block-start flag and on even parity. The sample is cut to 24, 20 or 16 bits, right-justified, and can be byte-swapped for big-endian consumers. Three status flags tell the reader what happened: ready, parity error and overrun. Reading the holding register is destructive and clears ready. Reading status clears the two sticky error flags.

Top module: `spdif_sample_fmt`

## Requirements
- R1: After reset, `rx_ready`, `parity_err` and `overrun` are 0, `hold_word` is 0, and the mode word is all zeros, so the receiver is off.
- R2: While mode bit 0 is 0, a subframe strobe loads nothing and sets no status flag.
- R3: With mode bit 1 at 1, a subframe whose validity bit is 1 is not loaded. With mode bit 1 at 0, the validity bit does not affect loading.
- R4: With mode bit 8 at 1, a subframe flagged as block start is not loaded. With mode bit 8 at 0, the flag does not affect loading.
- R5: Parity is even over the 24 audio bits plus the V, U, C and P bits. With mode bit 3 at 0, a subframe failing parity is not loaded and sets `parity_err` one cycle after its strobe. With mode bit 3 at 1, the subframe loads and `parity_err` stays clear.
- R6: Mode bits 5:4 select the width. Code 0 keeps audio[23:0], code 1 keeps audio[23:4] and code 2 keeps audio[23:8]. Code 3 behaves as code 0. The kept bits are right-justified and zero-extended into 32 bits.
- R7: Mode bit 2 at 0 leaves that 32-bit word as is. At 1, the word's four bytes are reversed, so byte 0 goes to bits 31:24 and byte 3 goes to bits 7:0.
- R8: A load updates `hold_word` and sets `rx_ready` one cycle after the strobe. A `hold_rd` pulse with no load clears `rx_ready` one cycle later. A load in the same cycle as `hold_rd` leaves `rx_ready` at 1 and sets no overrun.
- R9: A load while `rx_ready` is 1 and no `hold_rd` is present sets `overrun`, and the new word replaces the old one.
- R10: `overrun` and `parity_err` stay set until a `stat_rd` pulse clears them. A new set condition in the same cycle as `stat_rd` wins.
- R11: A `hold_rd` pulse while `rx_ready` is 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 16 | Mode word value |
| sf_stb | input | 1 | One subframe present this cycle |
| sf_audio | input | 24 | Audio field of the subframe |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User bit |
| sf_c | input | 1 | Channel-status bit |
| sf_p | input | 1 | Parity bit |
| sf_blk | input | 1 | Block-start flag |
| hold_rd | input | 1 | Destructive read of the holding register |
| stat_rd | input | 1 | Status read, clears sticky flags |
| hold_word | output | 32 | Holding register contents |
| rx_ready | output | 1 | A sample is waiting |
| parity_err | output | 1 | Sticky parity failure flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two pairs of events can land in the same clock cycle. A new load can coincide with the reader consuming the previous sample, and a new overrun can coincide with the status read that should clear it. The bench provokes both by raising `sf_stb` together with `hold_rd` while a sample is pending, and then `sf_stb` together with `stat_rd`. It judges the results at the ports: in the first case `rx_ready` must stay 1 with no overrun and the new word visible, and in the second case `overrun` must survive the read. A sweep over every width code, both byte orders and several audio patterns checks the output arithmetic against a bench-side model.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    localparam int AUDIO_W = 24;
    localparam int WORD_W  = 32;
    localparam int MODE_W  = 16;
    localparam int NBYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        WID_24  = 2'd0,
        WID_20  = 2'd1,
        WID_16  = 2'd2,
        WID_RSV = 2'd3
    } width_e;

    typedef struct packed {
        logic   drop_blk_start;
        width_e width;
        logic   par_off;
        logic   big_end;
        logic   drop_invalid;
        logic   rx_on;
    } mode_t;

    typedef struct packed {
        logic [AUDIO_W-1:0] audio;
        logic               v;
        logic               u;
        logic               c;
        logic               p;
        logic               blk;
    } subframe_t;

    function automatic mode_t decode_mode(input logic [MODE_W-1:0] w);
        mode_t m;
        m.rx_on          = w[0];
        m.drop_invalid   = w[1];
        m.big_end        = w[2];
        m.par_off        = w[3];
        m.width          = width_e'(w[5:4]);
        m.drop_blk_start = w[8];
        return m;
    endfunction

    function automatic logic parity_odd(input subframe_t s);
        return ^{s.audio, s.v, s.u, s.c, s.p};
    endfunction

    function automatic logic [WORD_W-1:0] justify(input logic [AUDIO_W-1:0] a,
                                                  input width_e wd);
        logic [WORD_W-1:0] r;
        case (wd)
            WID_20:  r = WORD_W'(a[AUDIO_W-1:4]);
            WID_16:  r = WORD_W'(a[AUDIO_W-1:8]);
            default: r = WORD_W'(a);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfmt_mode_reg.sv
module sfmt_mode_reg
    import sfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output mode_t             mode
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= decode_mode(wdata);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/sfmt_accept.sv
module sfmt_accept
    import sfmt_pkg::*;
(
    input  mode_t     mode,
    input  logic      stb,
    input  subframe_t sf,
    output logic      load,
    output logic      par_fail
);
    logic live;
    logic bad_par;
    logic veto_valid;
    logic veto_blk;

    always_comb begin
        live       = stb && mode.rx_on;
        bad_par    = !mode.par_off && parity_odd(sf);
        veto_valid = mode.drop_invalid && sf.v;
        veto_blk   = mode.drop_blk_start && sf.blk;
        par_fail   = live && bad_par;
        load       = live && !bad_par && !veto_valid && !veto_blk;
    end
endmodule

// File: rtl/sfmt_pack.sv
module sfmt_pack
    import sfmt_pkg::*;
(
    input  logic [AUDIO_W-1:0] audio,
    input  width_e             width,
    input  logic               big_end,
    output logic [WORD_W-1:0]  word
);
    logic [WORD_W-1:0] just;
    logic [WORD_W-1:0] swapped;

    assign just = justify(audio, width);

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = just[8*(NBYTES-1-b) +: 8];
    end

    assign word = big_end ? swapped : just;
endmodule

// File: rtl/sfmt_holding.sv
module sfmt_holding
    import sfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              par_fail,
    input  logic              hold_rd,
    input  logic              stat_rd,
    output logic [WORD_W-1:0] hold_word,
    output logic              rdy,
    output logic              ovr,
    output logic              perr
);
    logic [WORD_W-1:0] word_q;
    logic              rdy_q;
    logic              ovr_q;
    logic              perr_q;
    logic              ovr_set;

    assign ovr_set = load && rdy_q && !hold_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rdy_q  <= 1'b0;
        end else if (load) begin
            word_q <= word_in;
            rdy_q  <= 1'b1;
        end else if (hold_rd) begin
            rdy_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (ovr_set)      ovr_q <= 1'b1;
            else if (stat_rd) ovr_q <= 1'b0;
            if (par_fail)     perr_q <= 1'b1;
            else if (stat_rd) perr_q <= 1'b0;
        end
    end

    assign hold_word = word_q;
    assign rdy       = rdy_q;
    assign ovr       = ovr_q;
    assign perr      = perr_q;
endmodule

// File: rtl/spdif_sample_fmt.sv
module spdif_sample_fmt
    import sfmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_we,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               sf_stb,
    input  logic [AUDIO_W-1:0] sf_audio,
    input  logic               sf_v,
    input  logic               sf_u,
    input  logic               sf_c,
    input  logic               sf_p,
    input  logic               sf_blk,
    input  logic               hold_rd,
    input  logic               stat_rd,
    output logic [WORD_W-1:0]  hold_word,
    output logic               rx_ready,
    output logic               parity_err,
    output logic               overrun
);
    mode_t             mode;
    subframe_t         sf;
    logic              load;
    logic              par_fail;
    logic [WORD_W-1:0] packed_word;

    assign sf = '{audio: sf_audio, v: sf_v, u: sf_u, c: sf_c, p: sf_p, blk: sf_blk};

    sfmt_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    sfmt_accept u_accept (
        .mode     (mode),
        .stb      (sf_stb),
        .sf       (sf),
        .load     (load),
        .par_fail (par_fail)
    );

    sfmt_pack u_pack (
        .audio   (sf_audio),
        .width   (mode.width),
        .big_end (mode.big_end),
        .word    (packed_word)
    );

    sfmt_holding u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .word_in   (packed_word),
        .par_fail  (par_fail),
        .hold_rd   (hold_rd),
        .stat_rd   (stat_rd),
        .hold_word (hold_word),
        .rdy       (rx_ready),
        .ovr       (overrun),
        .perr      (parity_err)
    );
endmodule

// File: rtl/sfmt_checker.sv
module sfmt_checker (
    input logic clk,
    input logic rst,
    input logic rx_on,
    input logic load,
    input logic par_fail,
    input logic hold_rd,
    input logic stat_rd,
    input logic rdy,
    input logic ovr,
    input logic perr
);
    // R2
    rx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_on |=> !$rose(rdy));

    // R8
    load_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> rdy);

    // R8
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_rd && !load) |=> !rdy);

    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (load && rdy && !hold_rd) |=> ovr);

    // R5
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        par_fail |=> perr);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !stat_rd) |=> ovr);

    // R10
    parity_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (perr && !stat_rd) |=> perr);
endmodule

bind spdif_sample_fmt sfmt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_on    (mode.rx_on),
    .load     (load),
    .par_fail (par_fail),
    .hold_rd  (hold_rd),
    .stat_rd  (stat_rd),
    .rdy      (rx_ready),
    .ovr      (overrun),
    .perr     (parity_err)
);

// File: tb/spdif_sample_fmt_bench.sv
`timescale 1ns/1ps
module spdif_sample_fmt_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic        sf_stb = 1'b0;
    logic [23:0] sf_audio = '0;
    logic        sf_v = 1'b0, sf_u = 1'b0, sf_c = 1'b0, sf_p = 1'b0, sf_blk = 1'b0;
    logic        hold_rd = 1'b0;
    logic        stat_rd = 1'b0;
    logic [31:0] hold_word;
    logic        rx_ready, parity_err, overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spdif_sample_fmt u_spdif_sample_fmt (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .sf_stb(sf_stb), .sf_audio(sf_audio), .sf_v(sf_v), .sf_u(sf_u),
        .sf_c(sf_c), .sf_p(sf_p), .sf_blk(sf_blk), .hold_rd(hold_rd),
        .stat_rd(stat_rd), .hold_word(hold_word), .rx_ready(rx_ready),
        .parity_err(parity_err), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [23:0] a, input int code, input bit big);
        logic [31:0] w;
        if (code == 1)      w = {8'h0, a} >> 4;
        else if (code == 2) w = {8'h0, a} >> 8;
        else                w = {8'h0, a};
        if (big) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
        return w;
    endfunction

    function automatic logic [15:0] mk_mode(input bit on, input bit dv, input bit big,
                                            input bit poff, input int code, input bit db);
        logic [15:0] m = '0;
        m[0] = on; m[1] = dv; m[2] = big; m[3] = poff;
        m[5:4] = code[1:0]; m[8] = db;
        return m;
    endfunction

    task automatic set_mode(input logic [15:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // one cycle with optional subframe, holding read and status read
    task automatic cycle(input bit stb, input logic [23:0] a, input bit v, input bit blk,
                         input bit badpar, input bit hr, input bit sr);
        @(negedge clk);
        sf_stb = stb; sf_audio = a; sf_v = v; sf_blk = blk;
        sf_u = a[3]; sf_c = a[17];
        sf_p = (^{a, v, a[3], a[17]}) ^ badpar;
        hold_rd = hr; stat_rd = sr;
        @(negedge clk);
        sf_stb = 1'b0; hold_rd = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic drain();
        cycle(0, '0, 0, 0, 0, 1, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, rx_ready}, 0);
        chk("R1 overrun", {31'b0, overrun}, 0);
        chk("R1 parity", {31'b0, parity_err}, 0);
        chk("R1 word", hold_word, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after release", {31'b0, rx_ready}, 0);

        // R2 receiver off: good and bad subframes both ignored
        cycle(1, 24'h123456, 0, 0, 0, 0, 0);
        chk("R2 no load", {31'b0, rx_ready}, 0);
        chk("R2 word kept", hold_word, 0);
        cycle(1, 24'h654321, 0, 0, 1, 0, 0);
        chk("R2 no parity flag", {31'b0, parity_err}, 0);

        // R6 R7 sweep over width codes, byte orders and patterns
        for (int code = 0; code < 4; code++) begin
            for (int big = 0; big < 2; big++) begin
                set_mode(mk_mode(1, 0, big[0], 0, code, 0));
                for (int k = 0; k < 6; k++) begin
                    logic [23:0] a;
                    a = (k == 0) ? 24'hFFFFFF : 24'hA5C3E1 ^ 24'(k * 24'h13579B);
                    cycle(1, a, k[0], k[1], 0, 0, 0);
                    chk((big != 0) ? "R7 big-endian word" : "R6 width word",
                        hold_word, model(a, code, big[0]));
                    chk("R8 ready set", {31'b0, rx_ready}, 1);
                    cycle(0, '0, 0, 0, 0, 1, 0);
                    chk("R8 ready cleared", {31'b0, rx_ready}, 0);
                end
            end
        end
        chk("R9 no overrun in sweep", {31'b0, overrun}, 0);

        // R3 validity filtering
        set_mode(mk_mode(1, 1, 0, 0, 0, 0));
        cycle(1, 24'h00AA55, 1, 0, 0, 0, 0);
        chk("R3 invalid dropped", {31'b0, rx_ready}, 0);
        cycle(1, 24'h00AA56, 0, 0, 0, 0, 0);
        chk("R3 valid loaded", hold_word, 32'h0000AA56);
        drain();
        set_mode(mk_mode(1, 0, 0, 0, 0, 0));
        cycle(1, 24'h00AA57, 1, 0, 0, 0, 0);
        chk("R3 invalid kept when off", hold_word, 32'h0000AA57);
        drain();

        // R4 block-start filtering
        set_mode(mk_mode(1, 0, 0, 0, 0, 1));
        cycle(1, 24'h111111, 0, 1, 0, 0, 0);
        chk("R4 block start dropped", {31'b0, rx_ready}, 0);
        cycle(1, 24'h222222, 0, 0, 0, 0, 0);
        chk("R4 normal loaded", hold_word, 32'h00222222);
        drain();
        set_mode(mk_mode(1, 0, 0, 0, 0, 0));
        cycle(1, 24'h333333, 0, 1, 0, 0, 0);
        chk("R4 block start kept when off", hold_word, 32'h00333333);
        drain();

        // R5 parity
        cycle(1, 24'h444444, 0, 0, 1, 0, 0);
        chk("R5 bad parity not loaded", {31'b0, rx_ready}, 0);
        chk("R5 parity flag set", {31'b0, parity_err}, 1);
        cycle(0, '0, 0, 0, 0, 0, 0);
        chk("R10 parity flag sticky", {31'b0, parity_err}, 1);
        cycle(0, '0, 0, 0, 0, 0, 1);
        chk("R10 parity flag cleared", {31'b0, parity_err}, 0);
        set_mode(mk_mode(1, 0, 0, 1, 0, 0));
        cycle(1, 24'h555555, 0, 0, 1, 0, 0);
        chk("R5 check off loads", hold_word, 32'h00555555);
        chk("R5 check off no flag", {31'b0, parity_err}, 0);

        // R9 overrun: pending sample, second load without read
        cycle(1, 24'h666666, 0, 0, 0, 0, 0);
        chk("R9 overrun set", {31'b0, overrun}, 1);
        chk("R9 newer word", hold_word, 32'h00666666);
        cycle(0, '0, 0, 0, 0, 0, 1);
        chk("R10 overrun cleared", {31'b0, overrun}, 0);
        chk("R10 ready untouched by status read", {31'b0, rx_ready}, 1);

        // R8 load coincides with read
        cycle(1, 24'h777777, 0, 0, 0, 1, 0);
        chk("R8 same-cycle ready", {31'b0, rx_ready}, 1);
        chk("R8 same-cycle no overrun", {31'b0, overrun}, 0);
        chk("R8 same-cycle word", hold_word, 32'h00777777);

        // R10 overrun set coincides with status read
        cycle(1, 24'h888888, 0, 0, 0, 0, 1);
        chk("R10 set wins", {31'b0, overrun}, 1);
        drain();
        chk("R10 drained", {31'b0, overrun}, 0);

        // R11 read with nothing pending
        cycle(0, '0, 0, 0, 0, 1, 0);
        chk("R11 ready stays low", {31'b0, rx_ready}, 0);
        chk("R11 word unchanged", hold_word, 32'h00888888);
        chk("R11 no overrun", {31'b0, overrun}, 0);

        // R2 disabling stops loads of a pending state
        set_mode(mk_mode(0, 0, 0, 0, 0, 0));
        cycle(1, 24'h999999, 0, 0, 0, 0, 0);
        chk("R2 disabled after use", hold_word, 32'h00888888);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule